// File: doc/BRIEF.md
# Wave-Ordered Memory Request Sequencer

A dataflow fabric produces load and store requests in whatever order its operands arrive. This sequencer accepts those requests out of order, holds early arrivals in a small reorder buffer, and sends them to memory one at a time in program order. Program order is defined by a wave number (major key) and a per-wave sequence number (minor key).

The ordering is not taken from a central queue. Each request carries the sequence numbers of the operation before it and the operation after it, and the sequencer follows this chain of links. A link that a branch decides may be given as a wildcard. The sequencer then resolves the step from the link that the neighbouring operation does know. This lets a wave skip operations on an untaken path.

When an operation whose successor link is the end marker issues, the wave is finished and the sequencer moves to the next wave. Issued requests go to a memory with a fixed one-cycle latency. Each load returns its data tagged with the wave and sequence number of the request.

Top module: `wo_sequencer`

## Requirements
- R1: After reset, in_ready is 1 and both iss_valid and resp_valid are 0. The sequencer waits for wave 0 with nothing issued in it, and the memory reads as all zeros.
- R2: The first operation of a wave to issue is the buffered request of the current wave whose predecessor field is the marker value (all ones, 15). This holds even when it arrives after other requests of the same wave.
- R3: Once a wave has issued a request, the next request to issue is the one of the same wave whose predecessor field equals the sequence number issued last. Valid sequence numbers are 0 to 13.
- R4: A request whose predecessor field is the wildcard (14) issues after the request whose successor field names its sequence number.
- R5: When the last issued request has the wildcard (14) as its successor field, the next request to issue is the one whose predecessor field equals that request's sequence number.
- R6: Issuing a request whose successor field is the marker (15) closes the wave: the current wave becomes wave+1 and the next issue must again be a chain head. Requests of a later wave never issue while an earlier wave is open.
- R7: The buffer holds 8 requests. in_ready is 0 exactly while all 8 are occupied, and a request offered then is not taken.
- R8: At most one request issues per cycle. A request that can issue appears on iss_* one cycle after the edge that accepts it or that issues its predecessor. A ready chain therefore issues on consecutive cycles.
- R9: A load returns resp_valid one cycle after its issue, with its wave and sequence number. Its data is that of the latest store to the same address that issued earlier. Stores give no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Buffer has a free entry |
| in_wave | input | 4 | Wave number of the request |
| in_seq | input | 4 | Sequence number within the wave |
| in_pred | input | 4 | Predecessor link (15 chain head, 14 wildcard) |
| in_succ | input | 4 | Successor link (15 wave end, 14 wildcard) |
| in_store | input | 1 | 1 for store, 0 for load |
| in_addr | input | 4 | Word address |
| in_wdata | input | 16 | Store data |
| iss_valid | output | 1 | A request issued to memory this cycle |
| iss_wave | output | 4 | Wave of the issued request |
| iss_seq | output | 4 | Sequence number of the issued request |
| iss_store | output | 1 | Issued request is a store |
| resp_valid | output | 1 | Load data valid |
| resp_wave | output | 4 | Wave of the answered load |
| resp_seq | output | 4 | Sequence number of the answered load |
| resp_data | output | 16 | Load data |

## Verification
The link assertions assume well-formed waves from the fabric:
- sequence numbers are unique within a wave;
- every chain starts with exactly one head;
- no step has a wildcard on both of its sides;
- each wave ends in exactly one operation that carries the end marker.

The stimulus builds every wave by hand under these rules. It sends each wave's requests in a scrambled order, and sends some requests of a later wave early. It fills the buffer to capacity only with a set whose chain head is among the eight, so the buffer always drains.

// File: rtl/wo_pkg.sv
package wo_pkg;
    localparam int SEQ_W  = 4;
    localparam int WAVE_W = 4;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 16;

    typedef logic [SEQ_W-1:0]  seq_t;
    typedef logic [WAVE_W-1:0] wave_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;

    // all ones: chain head in a predecessor field, wave end in a successor field
    localparam seq_t SEQ_MARK = {SEQ_W{1'b1}};
    // one below all ones: link left open by a branch
    localparam seq_t SEQ_WILD = {{(SEQ_W-1){1'b1}}, 1'b0};

    typedef struct packed {
        wave_t wave;
        seq_t  seq;
        seq_t  pred;
        seq_t  succ;
        logic  store;
        addr_t addr;
        data_t wdata;
    } mreq_t;

    typedef struct packed {
        wave_t wave;       // wave being issued
        logic  open;       // at least one request of this wave issued
        seq_t  last;       // sequence number issued last
        seq_t  last_succ;  // successor link of that request
    } chain_t;

    function automatic logic may_issue(input mreq_t r, input chain_t c);
        if (r.wave != c.wave) return 1'b0;
        if (!c.open)          return r.pred == SEQ_MARK;
        return (r.pred == c.last) ||
               ((r.pred == SEQ_WILD) && (c.last_succ == r.seq));
    endfunction
endpackage

// File: rtl/wo_buffer.sv
module wo_buffer
    import wo_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   in_valid,
    input  mreq_t  in_req,
    output logic   in_ready,
    input  chain_t chain,
    input  logic   take,
    output logic   sel_valid,
    output mreq_t  sel_req
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0] valid_q;
    mreq_t            ent_q [DEPTH];
    logic [DEPTH-1:0] hit;
    logic [IDX_W-1:0] free_idx, sel_idx;
    logic             free_any;

    for (genvar g = 0; g < DEPTH; g++) begin : g_match
        assign hit[g] = valid_q[g] && may_issue(ent_q[g], chain);
    end

    always_comb begin
        free_any  = 1'b0;
        free_idx  = '0;
        sel_valid = 1'b0;
        sel_idx   = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!valid_q[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
            if (hit[i]) begin
                sel_valid = 1'b1;
                sel_idx   = IDX_W'(i);
            end
        end
    end

    assign in_ready = free_any;
    assign sel_req  = ent_q[sel_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else begin
            if (in_valid && in_ready) begin
                valid_q[free_idx] <= 1'b1;
                ent_q[free_idx]   <= in_req;
            end
            if (take) valid_q[sel_idx] <= 1'b0;
        end
    end

    // an offer made while every entry is occupied adds nothing
    assert_hold_when_full_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_ready) |=> ($countones(valid_q) <= $past($countones(valid_q))));
endmodule

// File: rtl/wo_chain.sv
module wo_chain
    import wo_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   take,
    input  mreq_t  req,
    output chain_t state
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= '0;
        end else if (take) begin
            if (req.succ == SEQ_MARK) begin
                state.wave <= state.wave + 1'b1;
                state.open <= 1'b0;
            end else begin
                state.open <= 1'b1;
            end
            state.last      <= req.seq;
            state.last_succ <= req.succ;
        end
    end
endmodule

// File: rtl/wo_mem.sv
module wo_mem
    import wo_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  iss_valid,
    input  mreq_t iss_req,
    output logic  resp_valid,
    output wave_t resp_wave,
    output seq_t  resp_seq,
    output data_t resp_data
);
    localparam int WORDS = 1 << ADDR_W;

    data_t mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
            resp_valid <= 1'b0;
            resp_wave  <= '0;
            resp_seq   <= '0;
            resp_data  <= '0;
        end else begin
            resp_valid <= iss_valid && !iss_req.store;
            resp_wave  <= iss_req.wave;
            resp_seq   <= iss_req.seq;
            resp_data  <= mem_q[iss_req.addr];
            if (iss_valid && iss_req.store) mem_q[iss_req.addr] <= iss_req.wdata;
        end
    end

    assert_resp_tag_R9: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> ($past(iss_valid) && !$past(iss_req.store) &&
                        resp_seq == $past(iss_req.seq) && resp_wave == $past(iss_req.wave)));
endmodule

// File: rtl/wo_sequencer.sv
module wo_sequencer
    import wo_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WAVE_W-1:0] in_wave,
    input  logic [SEQ_W-1:0]  in_seq,
    input  logic [SEQ_W-1:0]  in_pred,
    input  logic [SEQ_W-1:0]  in_succ,
    input  logic              in_store,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    output logic              iss_valid,
    output logic [WAVE_W-1:0] iss_wave,
    output logic [SEQ_W-1:0]  iss_seq,
    output logic              iss_store,
    output logic              resp_valid,
    output logic [WAVE_W-1:0] resp_wave,
    output logic [SEQ_W-1:0]  resp_seq,
    output logic [DATA_W-1:0] resp_data
);
    mreq_t  in_req, sel_req, iss_q;
    chain_t chain;
    logic   sel_valid, iss_vq;

    assign in_req = '{wave: in_wave, seq: in_seq, pred: in_pred, succ: in_succ,
                      store: in_store, addr: in_addr, wdata: in_wdata};

    wo_buffer #(.DEPTH(DEPTH)) u_buf (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_req(in_req),
        .in_ready(in_ready), .chain(chain), .take(sel_valid),
        .sel_valid(sel_valid), .sel_req(sel_req)
    );

    wo_chain u_chain (
        .clk(clk), .rst(rst), .take(sel_valid), .req(sel_req), .state(chain)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            iss_vq <= 1'b0;
            iss_q  <= '0;
        end else begin
            iss_vq <= sel_valid;
            iss_q  <= sel_req;
        end
    end

    assign iss_valid = iss_vq;
    assign iss_wave  = iss_q.wave;
    assign iss_seq   = iss_q.seq;
    assign iss_store = iss_q.store;

    wo_mem u_mem (
        .clk(clk), .rst(rst), .iss_valid(iss_vq), .iss_req(iss_q),
        .resp_valid(resp_valid), .resp_wave(resp_wave),
        .resp_seq(resp_seq), .resp_data(resp_data)
    );

    assert_head_first_R2: assert property (@(posedge clk) disable iff (rst)
        (iss_vq && iss_q.pred == SEQ_MARK) |-> !$past(chain.open));

    assert_link_known_R3: assert property (@(posedge clk) disable iff (rst)
        (iss_vq && $past(chain.open) && iss_q.pred != SEQ_WILD) |->
            (iss_q.pred == $past(chain.last)));

    assert_link_wild_R4: assert property (@(posedge clk) disable iff (rst)
        (iss_vq && iss_q.pred == SEQ_WILD) |->
            ($past(chain.open) && $past(chain.last_succ) == iss_q.seq));

    assert_current_wave_R6: assert property (@(posedge clk) disable iff (rst)
        iss_vq |-> (iss_q.wave == $past(chain.wave)));

    assert_wave_close_R6: assert property (@(posedge clk) disable iff (rst)
        (iss_vq && iss_q.succ == SEQ_MARK) |->
            (chain.wave == $past(chain.wave) + 1'b1 && !chain.open));
endmodule

// File: tb/tb_wo_sequencer.sv
module tb_wo_sequencer;
    import wo_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0, in_store = 1'b0;
    logic [3:0] in_wave = '0, in_seq = '0, in_pred = '0, in_succ = '0, in_addr = '0;
    logic [15:0] in_wdata = '0;
    logic in_ready, iss_valid, iss_store, resp_valid;
    logic [3:0] iss_wave, iss_seq, resp_wave, resp_seq;
    logic [15:0] resp_data;

    always #10 clk = ~clk;   // 50 MHz

    wo_sequencer dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_wave(in_wave), .in_seq(in_seq), .in_pred(in_pred), .in_succ(in_succ),
        .in_store(in_store), .in_addr(in_addr), .in_wdata(in_wdata),
        .iss_valid(iss_valid), .iss_wave(iss_wave), .iss_seq(iss_seq),
        .iss_store(iss_store), .resp_valid(resp_valid), .resp_wave(resp_wave),
        .resp_seq(resp_seq), .resp_data(resp_data)
    );

    localparam logic [3:0] M = 4'hF;  // head / end marker
    localparam logic [3:0] W = 4'hE;  // wildcard

    int vectors = 0;
    int fails   = 0;
    logic [8:0]  exp_iss  [$];   // {wave, seq, store}
    logic [23:0] exp_resp [$];   // {wave, seq, data}
    logic [15:0] model [16];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // program-order scoreboard entry
    task automatic expect_op(input logic [3:0] w, input logic [3:0] s, input logic st,
                             input logic [3:0] a, input logic [15:0] d);
        exp_iss.push_back({w, s, st});
        if (st) model[a] = d;
        else    exp_resp.push_back({w, s, model[a]});
    endtask

    // driver: called at a falling edge, returns at the falling edge after acceptance
    task automatic send(input logic [3:0] w, input logic [3:0] s, input logic [3:0] p,
                        input logic [3:0] n, input logic st, input logic [3:0] a,
                        input logic [15:0] d);
        logic r;
        in_wave = w; in_seq = s; in_pred = p; in_succ = n;
        in_store = st; in_addr = a; in_wdata = d; in_valid = 1'b1;
        do begin
            #1 r = in_ready;
            @(negedge clk);
        end while (!r);
        in_valid = 1'b0;
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (iss_valid) begin
                if (exp_iss.size() == 0) chk("R3 unexpected issue", {iss_wave, iss_seq, iss_store}, 9'h1FF);
                else chk("R3 issue order", {iss_wave, iss_seq, iss_store}, exp_iss.pop_front());
            end
            if (resp_valid) begin
                if (exp_resp.size() == 0) chk("R9 unexpected response", {resp_wave, resp_seq, resp_data}, 24'hFFFFFF);
                else chk("R9 load response", {resp_wave, resp_seq, resp_data}, exp_resp.pop_front());
            end
        end
    end

    // watchdog
    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) model[i] = 16'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 ready after reset", in_ready, 1);
        chk("R1 no issue after reset", iss_valid, 0);
        chk("R1 no response after reset", resp_valid, 0);
        @(negedge clk);

        // wave 0: head arrives last, chain 0-1-2-3 (R2, R3, R8, R9)
        expect_op(0, 0, 1, 3, 16'hA5A5);
        expect_op(0, 1, 0, 3, 16'h0);
        expect_op(0, 2, 0, 4, 16'h0);
        expect_op(0, 3, 1, 4, 16'h1234);
        send(0, 2, 1, 3, 0, 4, 0);
        send(0, 3, 2, M, 1, 4, 16'h1234);
        send(0, 1, 0, 2, 0, 3, 0);
        send(0, 0, M, 1, 1, 3, 16'hA5A5);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); #1;
            chk("R8 consecutive issue", iss_valid, 1);
        end
        @(negedge clk);

        // wave 2 head sent while wave 1 is still open (R6)
        expect_op(1, 0, 0, 4, 0);
        expect_op(1, 1, 1, 3, 16'h0F0F);
        expect_op(2, 0, 0, 3, 0);
        send(2, 0, M, M, 0, 3, 0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); #1;
            chk("R6 later wave held", iss_valid, 0);
        end
        @(negedge clk);
        send(1, 1, 0, M, 1, 3, 16'h0F0F);
        send(1, 0, M, 1, 0, 4, 0);
        repeat (6) @(negedge clk);

        // wave 3: wildcard predecessor resolved by neighbour's successor (R4)
        expect_op(3, 0, 1, 5, 16'h5555);
        expect_op(3, 3, 0, 5, 0);
        send(3, 3, W, M, 0, 5, 0);
        send(3, 0, M, 3, 1, 5, 16'h5555);
        repeat (6) @(negedge clk);

        // wave 4: wildcard successor, neighbour knows its predecessor (R5)
        expect_op(4, 0, 0, 5, 0);
        expect_op(4, 2, 1, 5, 16'h6666);
        send(4, 2, 0, M, 1, 5, 16'h6666);
        send(4, 0, M, W, 0, 5, 0);
        repeat (6) @(negedge clk);

        // wave 5: fill all 8 entries, head last (R7)
        for (int k = 0; k < 8; k++) expect_op(5, 4'(k), 0, 4'(k + 8), 0);
        expect_op(6, 0, 0, 5, 0);
        for (int k = 1; k < 8; k++)
            send(5, 4'(k), 4'(k - 1), (k == 7) ? M : 4'(k + 1), 0, 4'(k + 8), 0);
        send(5, 0, M, 1, 0, 8, 0);
        #1 chk("R7 ready low when full", in_ready, 0);
        send(6, 0, M, M, 0, 5, 0);

        for (int k = 0; k < 100 && (exp_iss.size() != 0 || exp_resp.size() != 0); k++)
            @(negedge clk);
        chk("R8 all issues seen", exp_iss.size(), 0);
        chk("R9 all responses seen", exp_resp.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule